// File: doc/BRIEF.md
# Read-Side Width and Endian Unpacker

This block sits between the 36-bit read side of a FIFO and a consumer that takes data in narrower pieces. Each long-word leaves the block in one of three ways: whole at full width, as two 18-bit halves, or as four 9-bit bytes. The piece order is most-significant-first or least-significant-first, whichever was chosen. The upstream FIFO is expected to present its head word on `fifo_data` whenever `fifo_empty` is low. The block consumes that word with a one-cycle `fifo_pop` pulse.

Transfer size and piece order are captured while master reset is held low. They then stay fixed until the next master reset. A partial reset flushes any piece still waiting and clears the output register, but keeps the captured configuration. The consumer reads with `rd_en`. It sees `out_empty`, which is high only when nothing at all is left to deliver.

Top module: `rd_unpacker`

## Requirements
- R1: The size code captured at master reset sets the pieces per long-word: 2'b00 gives one 36-bit piece, 2'b01 gives two 18-bit pieces, and 2'b10 or 2'b11 give four 9-bit pieces.
- R2: With `big_sel` captured as 1, pieces leave highest first. 9-bit piece k is long-word bits [9k+8:9k] and 18-bit piece j is bits [18j+17:18j]. Every piece appears in the low bits of `dout`, with the upper bits zero.
- R3: With `big_sel` captured as 0, pieces leave lowest first (byte 0, 1, 2, 3 or half 0, 1).
- R4: `size_sel` and `big_sel` are sampled on every rising edge while `mrst_n` is low. Changes to them while `mrst_n` is high do not affect the output order or size.
- R5: A partial reset (`prst_n` low) keeps the captured size and order. It discards the unread pieces of the current long-word, so the next read starts on a fresh long-word's first piece.
- R6: A rising edge with `mrst_n` or `prst_n` low sets `dout` to all zeroes, even with `rd_en` high.
- R7: A read happens only on a rising edge with `rd_en` high, `out_empty` low and both resets high. Without a read, `dout` holds its value and `fifo_pop` stays low.
- R8: `fifo_pop` is high exactly in the cycle whose read takes the first piece of a long-word, once per long-word, and never during reset.
- R9: `out_empty` is high only when `fifo_empty` is high and no unread piece of an already popped long-word remains.
- R10: After the last piece of a long-word, the next read delivers the first piece of the following long-word without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| size_sel | input | 2 | Transfer size code, sampled during master reset |
| big_sel | input | 1 | 1 = highest piece first, 0 = lowest first; sampled during master reset |
| fifo_data | input | 36 | Head long-word of the upstream FIFO |
| fifo_empty | input | 1 | Upstream FIFO holds no word |
| fifo_pop | output | 1 | Consumes the upstream head word on this edge |
| rd_en | input | 1 | Read request from the narrow side |
| dout | output | 36 | Registered output piece, zero-extended |
| out_empty | output | 1 | Nothing is available to read |

## Verification
The critical cycles are those where the last piece of one long-word is read while `rd_en` stays high. The next read must then pop the following word and deliver its first piece straight from `fifo_data`, with no bubble. The bench also pushes a word into an empty FIFO while `rd_en` is already high, and it holds `rd_en` high through both kinds of reset, so that a read and a reset fall on the same edge. A queue-based model follows each case on every clock and judges `dout`, `fifo_pop` and `out_empty`. In the collision cases reset must win: zero output, no pop, and the first piece of the next word afterwards.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int LANES = 4;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_FULL    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_QUARTER = 2'b10,
    SZ_QALT    = 2'b11
  } size_e;

  // index of the final piece for a given size
  function automatic logic [LANE_IDX_W-1:0] last_piece(size_e s);
    case (s)
      SZ_FULL: last_piece = '0;
      SZ_HALF: last_piece = LANE_IDX_W'(1);
      default: last_piece = LANE_IDX_W'(LANES - 1);
    endcase
  endfunction

  // lane to present for sequence position cnt
  function automatic logic [LANE_IDX_W-1:0] lane_of(logic big,
                                                    logic [LANE_IDX_W-1:0] last,
                                                    logic [LANE_IDX_W-1:0] cnt);
    lane_of = big ? (last - cnt) : cnt;
  endfunction
endpackage

// File: rtl/unpk_cfg.sv
module unpk_cfg
  import unpk_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  logic [1:0] size_in,
  input  logic       big_in,
  output size_e      cfg_size,
  output logic       cfg_big
);
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg_size <= size_e'(size_in);
      cfg_big  <= big_in;
    end
  end
endmodule

// File: rtl/unpk_seq.sv
module unpk_seq
  import unpk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_ok,
  input  logic                  rd_en,
  input  logic                  fifo_empty,
  input  logic [LANE_IDX_W-1:0] last,
  output logic [LANE_IDX_W-1:0] cnt,
  output logic                  hold_vld,
  output logic                  rd_fire,
  output logic                  pop,
  output logic                  load_hold,
  output logic                  out_empty
);
  logic avail;
  logic is_last;

  assign avail     = hold_vld | ~fifo_empty;
  assign out_empty = ~avail;
  assign rd_fire   = rst_ok & rd_en & avail;
  assign is_last   = (cnt == last);
  assign pop       = rd_fire & ~hold_vld;
  assign load_hold = pop & ~is_last;

  always_ff @(posedge clk) begin
    if (!rst_ok) begin
      cnt      <= '0;
      hold_vld <= 1'b0;
    end else if (rd_fire) begin
      cnt      <= is_last ? '0 : cnt + 1'b1;
      hold_vld <= ~is_last;
    end
  end
endmodule

// File: rtl/unpk_mux.sv
module unpk_mux
  import unpk_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int LONG_W = LANES * BYTE_W,
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_ok,
  input  logic                  load_hold,
  input  logic                  rd_fire,
  input  logic                  hold_vld,
  input  logic [LONG_W-1:0]     fifo_data,
  input  size_e                 cfg_size,
  input  logic [LANE_IDX_W-1:0] lane,
  output logic [LONG_W-1:0]     dout
);
  logic [LONG_W-1:0] hold_q;
  logic [LONG_W-1:0] src;
  logic [LONG_W-1:0] piece;
  logic [BYTE_W-1:0] q_lane [LANES];
  logic [HALF_W-1:0] h_lane [LANES/2];

  assign src = hold_vld ? hold_q : fifo_data;

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign q_lane[g] = src[g*BYTE_W +: BYTE_W];
  end
  for (genvar g = 0; g < LANES/2; g++) begin : g_half
    assign h_lane[g] = src[g*HALF_W +: HALF_W];
  end

  always_comb begin
    case (cfg_size)
      SZ_FULL: piece = src;
      SZ_HALF: piece = {{(LONG_W-HALF_W){1'b0}}, h_lane[lane[0]]};
      default: piece = {{(LONG_W-BYTE_W){1'b0}}, q_lane[lane]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_ok) begin
      hold_q <= '0;
      dout   <= '0;
    end else begin
      if (load_hold) hold_q <= fifo_data;
      if (rd_fire)   dout   <= piece;
    end
  end
endmodule

// File: rtl/rd_unpacker.sv
module rd_unpacker
  import unpk_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int LONG_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic [1:0]        size_sel,
  input  logic              big_sel,
  input  logic [LONG_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              rd_en,
  output logic [LONG_W-1:0] dout,
  output logic              out_empty
);
  size_e                 cfg_size_w;
  logic                  cfg_big_w;
  logic                  rst_ok_w;
  logic [LANE_IDX_W-1:0] last_w;
  logic [LANE_IDX_W-1:0] cnt_w;
  logic [LANE_IDX_W-1:0] lane_w;
  logic                  hold_vld_w;
  logic                  rd_fire_w;
  logic                  load_hold_w;

  assign rst_ok_w = mrst_n & prst_n;
  assign last_w   = last_piece(cfg_size_w);
  assign lane_w   = lane_of(cfg_big_w, last_w, cnt_w);

  unpk_cfg u_cfg (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .size_in  (size_sel),
    .big_in   (big_sel),
    .cfg_size (cfg_size_w),
    .cfg_big  (cfg_big_w)
  );

  unpk_seq u_seq (
    .clk        (clk),
    .rst_ok     (rst_ok_w),
    .rd_en      (rd_en),
    .fifo_empty (fifo_empty),
    .last       (last_w),
    .cnt        (cnt_w),
    .hold_vld   (hold_vld_w),
    .rd_fire    (rd_fire_w),
    .pop        (fifo_pop),
    .load_hold  (load_hold_w),
    .out_empty  (out_empty)
  );

  unpk_mux #(.BYTE_W(BYTE_W)) u_mux (
    .clk       (clk),
    .rst_ok    (rst_ok_w),
    .load_hold (load_hold_w),
    .rd_fire   (rd_fire_w),
    .hold_vld  (hold_vld_w),
    .fifo_data (fifo_data),
    .cfg_size  (cfg_size_w),
    .lane      (lane_w),
    .dout      (dout)
  );
endmodule

// File: rtl/rd_unpacker_chk.sv
module rd_unpacker_chk #(
  parameter int LONG_W = 36
) (
  input logic              clk,
  input logic              mrst_n,
  input logic              prst_n,
  input logic              rd_en,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              out_empty,
  input logic [LONG_W-1:0] dout,
  input logic [1:0]        cfg_size,
  input logic              cfg_big,
  input logic              hold_vld,
  input logic              rd_fire
);
  assert_pop_needs_read_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    fifo_pop |-> (rd_en && !out_empty && !hold_vld));

  assert_no_pop_in_reset_R8: assert property (@(posedge clk)
    (!mrst_n || !prst_n) |-> !fifo_pop);

  assert_empty_meaning_R9: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    out_empty |-> (fifo_empty && !hold_vld));

  assert_reset_zero_R6: assert property (@(posedge clk)
    (!mrst_n || !prst_n) |=> (dout == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    !rd_fire |=> $stable(dout));

  assert_full_pops_R1: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (rd_fire && cfg_size == 2'b00) |-> fifo_pop);

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(cfg_size) && $stable(cfg_big)));

  assert_partial_flush_R5: assert property (@(posedge clk)
    !prst_n |=> !hold_vld);
endmodule

bind rd_unpacker rd_unpacker_chk #(.LONG_W(LONG_W)) u_chk (
  .clk        (clk),
  .mrst_n     (mrst_n),
  .prst_n     (prst_n),
  .rd_en      (rd_en),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .out_empty  (out_empty),
  .dout       (dout),
  .cfg_size   (cfg_size_w),
  .cfg_big    (cfg_big_w),
  .hold_vld   (hold_vld_w),
  .rd_fire    (rd_fire_w)
);

// File: tb/rd_unpacker_tb_top.sv
module rd_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        prst_n = 1'b1;
  logic [1:0]  size_sel = 2'b00;
  logic        big_sel = 1'b1;
  logic [35:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic        rd_en = 1'b0;
  logic [35:0] dout;
  logic        out_empty;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [35:0] fq[$];
  logic [35:0] cur = '0;
  int          left = 0;
  int          m_pieces = 1;
  bit          m_big = 1;
  logic [35:0] exp_dout = '0;
  int          word_no = 0;

  always #2.5 clk = ~clk;

  rd_unpacker dut_i (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .size_sel(size_sel),
    .big_sel(big_sel), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .rd_en(rd_en), .dout(dout), .out_empty(out_empty)
  );

  function automatic logic [35:0] mk_word(int i);
    logic [35:0] v;
    v = 36'h9ABCDEF01 ^ (36'(i) * 36'h123456789);
    return v;
  endfunction

  function automatic int pieces_for(logic [1:0] code);
    if (code == 2'b00) return 1;
    if (code == 2'b01) return 2;
    return 4;
  endfunction

  function automatic logic [35:0] piece_of(logic [35:0] w, int n, bit big, int p);
    int width;
    int idx;
    logic [35:0] mask;
    width = 36 / n;
    idx   = big ? (n - 1 - p) : p;
    mask  = (width == 36) ? {36{1'b1}} : ((36'd1 << width) - 36'd1);
    return (w >> (idx * width)) & mask;
  endfunction

  task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic refresh_fifo();
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? 36'h0 : fq[0];
  endtask

  // one clock: drive, check pre-edge status, then post-edge output
  task automatic step(string req, bit rd, bit mr, bit pr, int pushes);
    bit in_rst;
    bit fire;
    bit exp_pop;
    bit exp_empty;
    @(negedge clk);
    rd_en  = rd;
    mrst_n = mr;
    prst_n = pr;
    #1;
    in_rst    = !mr || !pr;
    exp_empty = (left == 0) && (fq.size() == 0);
    fire      = rd && !exp_empty && !in_rst;
    exp_pop   = fire && (left == 0);
    check("R9", "out_empty", 36'(out_empty), 36'(exp_empty));
    check("R8", "fifo_pop", 36'(fifo_pop), 36'(exp_pop));
    @(posedge clk);
    #1;
    if (in_rst) begin
      exp_dout = '0;
      left = 0;
      if (!mr) begin
        m_pieces = pieces_for(size_sel);
        m_big    = big_sel;
      end
    end else if (fire) begin
      if (left == 0) begin
        cur  = fq.pop_front();
        left = m_pieces;
      end
      exp_dout = piece_of(cur, m_pieces, m_big, m_pieces - left);
      left--;
    end
    for (int k = 0; k < pushes; k++) begin
      fq.push_back(mk_word(word_no));
      word_no++;
    end
    refresh_fifo();
    check(req, "dout", dout, exp_dout);
  endtask

  task automatic master(logic [1:0] sz, bit big, int cyc);
    size_sel = sz;
    big_sel  = big;
    for (int k = 0; k < cyc; k++) step("R6", 1'b0, 1'b0, 1'b1, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    refresh_fifo();
    // R6 reset state, full width big
    master(2'b00, 1'b1, 4);
    // R1: full width pieces, back to back
    step("R1", 1'b0, 1'b1, 1'b1, 3);
    for (int k = 0; k < 4; k++) step("R1", 1'b1, 1'b1, 1'b1, 0);
    // R2 halves, highest first, R10 no bubble
    master(2'b01, 1'b1, 2);
    step("R2", 1'b0, 1'b1, 1'b1, 2);
    for (int k = 0; k < 5; k++) step("R10", 1'b1, 1'b1, 1'b1, 0);
    // R2 bytes, highest first, gapped reads (R7)
    master(2'b10, 1'b1, 2);
    step("R2", 1'b0, 1'b1, 1'b1, 2);
    for (int k = 0; k < 12; k++) step((k % 2) ? "R7" : "R2", 1'(k % 3 != 1), 1'b1, 1'b1, 0);
    for (int k = 0; k < 4; k++) step("R2", 1'b1, 1'b1, 1'b1, 0);
    // R3 bytes lowest first, code 2'b11
    master(2'b11, 1'b0, 2);
    step("R3", 1'b0, 1'b1, 1'b1, 2);
    for (int k = 0; k < 9; k++) step("R3", 1'b1, 1'b1, 1'b1, 0);
    // R3 halves lowest first; R4 pins change while running
    master(2'b01, 1'b0, 2);
    step("R3", 1'b0, 1'b1, 1'b1, 3);
    step("R3", 1'b1, 1'b1, 1'b1, 0);
    size_sel = 2'b10;
    big_sel  = 1'b1;
    for (int k = 0; k < 6; k++) step("R4", 1'b1, 1'b1, 1'b1, 0);
    // R5 partial reset mid-word keeps halves/lowest-first
    master(2'b01, 1'b0, 2);
    step("R5", 1'b0, 1'b1, 1'b1, 2);
    step("R5", 1'b1, 1'b1, 1'b1, 0);
    size_sel = 2'b00;
    big_sel  = 1'b1;
    step("R5", 1'b1, 1'b1, 1'b0, 0);
    step("R5", 1'b1, 1'b1, 1'b0, 0);
    for (int k = 0; k < 3; k++) step("R5", 1'b1, 1'b1, 1'b1, 0);
    // R7/R9: reads with nothing left, then a word arrives while rd_en high
    for (int k = 0; k < 3; k++) step("R7", 1'b1, 1'b1, 1'b1, 0);
    step("R9", 1'b1, 1'b1, 1'b1, 1);
    for (int k = 0; k < 3; k++) step("R9", 1'b1, 1'b1, 1'b1, 0);
    // R6: master reset with reads pending and rd_en high
    size_sel = 2'b10;
    big_sel  = 1'b0;
    step("R6", 1'b0, 1'b1, 1'b1, 2);
    step("R6", 1'b1, 1'b1, 1'b1, 0);
    step("R6", 1'b1, 1'b0, 1'b1, 0);
    step("R6", 1'b1, 1'b0, 1'b1, 0);
    for (int k = 0; k < 8; k++) step("R1", 1'b1, 1'b1, 1'b1, 0);
    step("R9", 1'b0, 1'b1, 1'b1, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule